// File: doc/BRIEF.md
# Stack Unit with Register-Cached Top Element

This block is the data-stack half of a 16-bit stack processor datapath. The element on top of the stack is held in its own register, and a register-array stack RAM holds every element below it. The stack pointer always names the RAM slot of the element directly under the top. Because of this, the two operands of a binary operation are available together in every cycle: one comes from the RAM at the pointer and the other from the top register. A two-operand ALU operation, with its implied pop, therefore completes in a single clock.

A sequencer drives one 4-bit command per cycle:

| Code | Command |
|------|---------|
| 0 | idle |
| 1 | push |
| 2 | pop |
| 3 | replace top |
| 4 | binary ALU op |
| 5 | push carry as a flag word |
| 6 | shift pair left |
| 7 | shift pair right |
| 8 | load temporary register |
| 9 to 15 | idle |

There are no condition flags in the programmer's view. A carry produced by add or subtract is kept in a register for the sequencer. The sequencer turns a carry into a data value by pushing it back as an all-zeros or all-ones word. A pointer port lets the sequencer read and overwrite the stack pointer, so that buried elements can be reached directly. A 16-bit temporary register sits beside the top register, and the two shift together as one 32-bit value for multiply and divide steps.

Top module: `tos_stack_unit`

## Requirements
- R1: While reset is asserted (active low), the pointer, top register, temporary register and carry register are all zero.
- R2: Command 1 (push) writes the old top into the RAM at pointer+1, increments the pointer and loads `din` into the top register, so the next cycle shows the old top on `second`.
- R3: Command 2 (pop) loads the top register from `second` and decrements the pointer.
- R4: Command 3 (replace) loads `din` into the top register and leaves the pointer and `second` unchanged.
- R5: Command 4 puts f(second, top) into the top register and decrements the pointer, all in one cycle. The operation f is chosen by `alu_sel`: 0 is second+top, 1 is second−top, 2 is AND, 3 is OR, 4 is XOR, and 5 to 7 pass the top through.
- R6: The carry register takes the carry out of bit 15 on an add. On a subtract it takes 1 when second ≥ top (no borrow) and 0 otherwise. Every other command leaves it unchanged.
- R7: Command 5 pushes 16'hFFFF when `carry_in` is 1 and 16'h0000 when it is 0, with the same pointer and RAM effect as a push.
- R8: When `sp_wr` is 1, the pointer loads `sp_din` and the command in that cycle is ignored, so the top and the RAM keep their values; `second` then shows the RAM word at the new pointer.
- R9: Command 6 shifts {top, tmp} left by one bit with a zero entering bit 0 of tmp. Command 7 shifts it right by one bit with a zero entering bit 15 of top.
- R10: Command 8 loads `din` into the temporary register and changes nothing else.
- R11: The pointer wraps modulo 256: a push at pointer 255 gives pointer 0, and a pop at pointer 0 gives pointer 255.
- R12: Commands 0 and 9 to 15 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 4 | Command code for this cycle |
| din | input | 16 | Data for push, replace and temporary load |
| alu_sel | input | 3 | ALU function for command 4 |
| carry_in | input | 1 | Carry value pushed by command 5 |
| sp_wr | input | 1 | Pointer write strobe |
| sp_din | input | 8 | Value written to the pointer |
| top | output | 16 | Top-of-stack register |
| second | output | 16 | RAM word at the pointer (element under the top) |
| sp | output | 8 | Stack pointer |
| tmp | output | 16 | Temporary register |
| carry | output | 1 | Carry from the last add or subtract |

## Verification
Every cycle, the assertions check the pointer step and the top value for push, pop, replace, flag push, ALU add and pointer load. They also check the push-to-second link, the 32-bit left shift, the temporary load, that the carry holds across logic operations, and that idle codes leave the state alone. The ALU results for subtract and the logic functions, and the carry across a chain of adds and subtracts, can only be shown by the bench's scenarios. The same goes for pointer wrap at both ends, for an overwritten pointer exposing a buried element, and for the right shift.

// File: rtl/tos_stack_unit.sv
module tos_stack_unit #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 256,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       cmd,
  input  logic [WIDTH-1:0] din,
  input  logic [2:0]       alu_sel,
  input  logic             carry_in,
  input  logic             sp_wr,
  input  logic [PW-1:0]    sp_din,
  output logic [WIDTH-1:0] top,
  output logic [WIDTH-1:0] second,
  output logic [PW-1:0]    sp,
  output logic [WIDTH-1:0] tmp,
  output logic             carry
);
  localparam logic [3:0] C_PUSH = 4'd1, C_POP = 4'd2, C_REPL = 4'd3, C_ALU = 4'd4,
                         C_PFLAG = 4'd5, C_SHL = 4'd6, C_SHR = 4'd7, C_LTMP = 4'd8;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] alu_y;
  logic [WIDTH:0]   sum, dif;
  logic [2*WIDTH-1:0] pair;

  wire [PW-1:0] sp_up = sp + 1'b1;
  wire [PW-1:0] sp_dn = sp - 1'b1;
  wire pushing = !sp_wr && (cmd == C_PUSH || cmd == C_PFLAG);

  assign second = mem[sp];
  assign sum  = {1'b0, second} + {1'b0, top};
  assign dif  = {1'b0, second} + {1'b0, ~top} + 1'b1;
  assign pair = {top, tmp};

  always_comb begin
    case (alu_sel)
      3'd0:    alu_y = sum[WIDTH-1:0];
      3'd1:    alu_y = dif[WIDTH-1:0];
      3'd2:    alu_y = second & top;
      3'd3:    alu_y = second | top;
      3'd4:    alu_y = second ^ top;
      default: alu_y = top;
    endcase
  end

  always_ff @(posedge clk) begin
    if (pushing) mem[sp_up] <= top;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp    <= '0;
      top   <= '0;
      tmp   <= '0;
      carry <= 1'b0;
    end else if (sp_wr) begin
      sp <= sp_din;
    end else begin
      case (cmd)
        C_PUSH:  begin top <= din; sp <= sp_up; end
        C_PFLAG: begin top <= {WIDTH{carry_in}}; sp <= sp_up; end
        C_POP:   begin top <= second; sp <= sp_dn; end
        C_REPL:  top <= din;
        C_ALU: begin
          top <= alu_y;
          sp  <= sp_dn;
          if (alu_sel == 3'd0) carry <= sum[WIDTH];
          else if (alu_sel == 3'd1) carry <= dif[WIDTH];
        end
        C_SHL:   {top, tmp} <= {pair[2*WIDTH-2:0], 1'b0};
        C_SHR:   {top, tmp} <= {1'b0, pair[2*WIDTH-1:1]};
        C_LTMP:  tmp <= din;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tos_stack_unit_chk.sv
module tos_stack_unit_chk #(
  parameter int WIDTH = 16,
  parameter int PW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       cmd,
  input logic [WIDTH-1:0] din,
  input logic [2:0]       alu_sel,
  input logic             carry_in,
  input logic             sp_wr,
  input logic [PW-1:0]    sp_din,
  input logic [WIDTH-1:0] top,
  input logic [WIDTH-1:0] second,
  input logic [PW-1:0]    sp,
  input logic [WIDTH-1:0] tmp,
  input logic             carry
);
  AST_PUSH_SP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sp_wr && cmd == 4'd1) |=> sp == $past(sp) + PW'(1)); // R2
  AST_PUSH_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (!sp_wr && cmd == 4'd1) |=> (second == $past(top) && top == $past(din))); // R2
  AST_POP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sp_wr && cmd == 4'd2) |=> (top == $past(second) && sp == $past(sp) - PW'(1))); // R3
  AST_REPLACE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sp_wr && cmd == 4'd3) |=> (sp == $past(sp) && second == $past(second) && top == $past(din))); // R4
  AST_ALU_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sp_wr && cmd == 4'd4 && alu_sel == 3'd0) |=> top == WIDTH'($past(second) + $past(top))); // R5
  AST_ALU_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sp_wr && cmd == 4'd4) |=> sp == $past(sp) - PW'(1)); // R5
  AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_wr || cmd != 4'd4 || alu_sel > 3'd1) |=> $stable(carry)); // R6
  AST_FLAG_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (!sp_wr && cmd == 4'd5) |=> (top == {WIDTH{$past(carry_in)}} && second == $past(top))); // R7
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr |=> (sp == $past(sp_din) && top == $past(top) && tmp == $past(tmp))); // R8
  AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (!sp_wr && cmd == 4'd6) |=> {top, tmp} == ({$past(top), $past(tmp)} << 1)); // R9
  AST_TMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sp_wr && cmd == 4'd8) |=> (tmp == $past(din) && top == $past(top) && sp == $past(sp))); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sp_wr && (cmd == 4'd0 || cmd > 4'd8)) |=> ($stable(top) && $stable(sp) && $stable(tmp) && $stable(carry))); // R12
endmodule

bind tos_stack_unit tos_stack_unit_chk #(.WIDTH(WIDTH), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .din(din), .alu_sel(alu_sel),
  .carry_in(carry_in), .sp_wr(sp_wr), .sp_din(sp_din), .top(top),
  .second(second), .sp(sp), .tmp(tmp), .carry(carry)
);

// File: tb/sim_tos_stack_unit.sv
`timescale 1ns/1ps
module sim_tos_stack_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] cmd = '0;
  logic [15:0] din = '0;
  logic [2:0] alu_sel = '0;
  logic carry_in = 1'b0, sp_wr = 1'b0;
  logic [7:0] sp_din = '0;
  logic [15:0] top, second, tmp;
  logic [7:0] sp;
  logic carry;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tos_stack_unit u0 (.clk(clk), .rst_n(rst_n), .cmd(cmd), .din(din), .alu_sel(alu_sel),
    .carry_in(carry_in), .sp_wr(sp_wr), .sp_din(sp_din), .top(top), .second(second),
    .sp(sp), .tmp(tmp), .carry(carry));

  // {cmd, din, alu_sel, carry_in, exp_top, exp_sp, exp_carry}
  localparam int NV = 25;
  localparam logic [48:0] VEC [NV] = '{
    {4'd1, 16'h1111, 3'd0, 1'b0, 16'h1111, 8'd1, 1'b0},  // R2
    {4'd1, 16'h2222, 3'd0, 1'b0, 16'h2222, 8'd2, 1'b0},
    {4'd1, 16'h0005, 3'd0, 1'b0, 16'h0005, 8'd3, 1'b0},
    {4'd4, 16'h0000, 3'd0, 1'b0, 16'h2227, 8'd2, 1'b0},  // R5 add
    {4'd4, 16'h0000, 3'd1, 1'b0, 16'hEEEA, 8'd1, 1'b0},  // R5 sub, R6 borrow
    {4'd1, 16'hF0F0, 3'd0, 1'b0, 16'hF0F0, 8'd2, 1'b0},
    {4'd4, 16'h0000, 3'd2, 1'b0, 16'hE0E0, 8'd1, 1'b0},  // and
    {4'd1, 16'h0FF0, 3'd0, 1'b0, 16'h0FF0, 8'd2, 1'b0},
    {4'd4, 16'h0000, 3'd3, 1'b0, 16'hEFF0, 8'd1, 1'b0},  // or
    {4'd1, 16'hFFFF, 3'd0, 1'b0, 16'hFFFF, 8'd2, 1'b0},
    {4'd4, 16'h0000, 3'd4, 1'b0, 16'h100F, 8'd1, 1'b0},  // xor
    {4'd3, 16'hABCD, 3'd0, 1'b0, 16'hABCD, 8'd1, 1'b0},  // R4
    {4'd2, 16'h0000, 3'd0, 1'b0, 16'h0000, 8'd0, 1'b0},  // R3
    {4'd1, 16'h8000, 3'd0, 1'b0, 16'h8000, 8'd1, 1'b0},
    {4'd1, 16'h9000, 3'd0, 1'b0, 16'h9000, 8'd2, 1'b0},
    {4'd4, 16'h0000, 3'd0, 1'b0, 16'h1000, 8'd1, 1'b1},  // R6 add carry out
    {4'd1, 16'h00FF, 3'd0, 1'b0, 16'h00FF, 8'd2, 1'b1},
    {4'd4, 16'h0000, 3'd2, 1'b0, 16'h0000, 8'd1, 1'b1},  // R6 hold on and
    {4'd1, 16'h0003, 3'd0, 1'b0, 16'h0003, 8'd2, 1'b1},
    {4'd4, 16'h0000, 3'd1, 1'b0, 16'hFFFD, 8'd1, 1'b0},  // R6 sub borrow
    {4'd1, 16'h0002, 3'd0, 1'b0, 16'h0002, 8'd2, 1'b0},
    {4'd4, 16'h0000, 3'd1, 1'b0, 16'hFFFB, 8'd1, 1'b1},  // R6 sub no borrow
    {4'd5, 16'h0000, 3'd0, 1'b1, 16'hFFFF, 8'd2, 1'b1},  // R7 set
    {4'd5, 16'h1234, 3'd0, 1'b0, 16'h0000, 8'd3, 1'b1},  // R7 clear
    {4'd0, 16'h5555, 3'd0, 1'b0, 16'h0000, 8'd3, 1'b1}   // R12
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] c, input logic [15:0] d);
    @(negedge clk);
    cmd = c; din = d;
    @(posedge clk); #1;
    cmd = 4'd0; sp_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 top", 32'(top), 32'h0);
    chk("R1 sp", 32'(sp), 32'h0);
    chk("R1 tmp", 32'(tmp), 32'h0);
    chk("R1 carry", 32'(carry), 32'h0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {cmd, din, alu_sel, carry_in} = VEC[i][48:25];
      @(posedge clk); #1;
      chk($sformatf("R2-R7 vec %0d top", i), 32'(top), 32'(VEC[i][24:9]));
      chk($sformatf("R2-R7 vec %0d sp", i), 32'(sp), 32'(VEC[i][8:1]));
      chk($sformatf("R6 vec %0d carry", i), 32'(carry), 32'(VEC[i][0]));
    end
    chk("R2 second after flag pushes", 32'(second), 32'hFFFF);

    step(4'd3, 16'h0001);
    chk("R4 second unchanged", 32'(second), 32'hFFFF);
    step(4'd8, 16'h8000);
    chk("R10 tmp load", 32'(tmp), 32'h8000);
    chk("R10 top kept", 32'(top), 32'h0001);
    step(4'd6, 16'h0);
    chk("R9 left top", 32'(top), 32'h0003);
    chk("R9 left tmp", 32'(tmp), 32'h0000);
    step(4'd7, 16'h0);
    chk("R9 right top", 32'(top), 32'h0001);
    chk("R9 right tmp", 32'(tmp), 32'h8000);

    @(negedge clk); sp_wr = 1'b1; sp_din = 8'd2;
    step(4'd1, 16'h7777);
    chk("R8 sp loaded", 32'(sp), 32'd2);
    chk("R8 push ignored", 32'(top), 32'h0001);
    chk("R8 buried element", 32'(second), 32'hFFFB);

    @(negedge clk); sp_wr = 1'b1; sp_din = 8'd255;
    step(4'd0, 16'h0);
    step(4'd1, 16'h1234);
    chk("R11 push wrap sp", 32'(sp), 32'd0);
    chk("R11 push wrap second", 32'(second), 32'h0001);
    step(4'd2, 16'h0);
    chk("R11 pop wrap sp", 32'(sp), 32'd255);
    chk("R11 pop wrap top", 32'(top), 32'h0001);

    step(4'd11, 16'hDEAD);
    chk("R12 idle top", 32'(top), 32'h0001);
    chk("R12 idle sp", 32'(sp), 32'd255);
    chk("R12 idle tmp", 32'(tmp), 32'h8000);

    done = 1'b1;
    finish_run();
  end
endmodule